// File: doc/BRIEF.md
# Keyboard Controller Host Status Interface

This block is the register face that a legacy keyboard/auxiliary-port controller presents to the host. The host reaches it over a byte-wide bus with a chip select, one address line, and read and write strobes. Address 0 is the data port and address 1 is the command/status port. The block holds one byte going toward the host (the output buffer), one byte coming from the host (the input buffer), and an 8-bit status word. Only the status word has meaning beyond the buffers. The serial line engine, the command interpreter and the timers sit on the internal side and are not part of this block.

Two enumerated state machines do the work.

- **Output buffer machine** (`OB_EMPTY`, `OB_FULL`):
  - `OB_EMPTY` moves to `OB_FULL` on a *load*. A load comes from a received byte, a receive timeout, or a device-reported parity fault.
  - `OB_FULL` returns to `OB_EMPTY` on a *host data read* that does not coincide with a load.
  - `OB_FULL` stays in `OB_FULL` on a *replace*: an error event overwrites the held byte with a fixed code.
- **Input buffer machine** (`IB_EMPTY`, `IB_FULL`):
  - `IB_EMPTY` moves to `IB_FULL` on a *host write* to either port.
  - `IB_FULL` returns to `IB_EMPTY` on *take*, when the internal side consumes the byte.
  - Host writes that arrive while the machine is in `IB_FULL` are dropped.

A small register holds the system flag. The status word is assembled from both machines, the flag, and the inhibit and transmit-busy inputs.

Top module: `kbd_host_regs`

## Requirements
- R1: A host read with `addr`=1 returns the status byte on `rdata` during the read cycle. It changes no state; in particular, status bit 0 stays as it was. When no read is in progress, `rdata` is 0.
- R2: A load sets status bit 0. A host read with `addr`=0 returns the output buffer byte on `rdata` in that cycle, and bit 0 is clear from the next cycle on.
- R3: `rx_ready` is 1 exactly when the output buffer is empty. A byte offered on `rx_valid` while the buffer is full is not taken, and the held byte is kept.
- R4: A host write to either port while status bit 1 is 0 captures `wdata`. It sets bit 1 and drives `in_valid`=1 with the byte on `in_byte`. `in_is_cmd` and status bit 3 become 1 for `addr`=1 and 0 for `addr`=0, and bit 3 keeps that value after the byte is taken. A cycle with `in_take` high empties the buffer and clears bit 1.
- R5: A host write while the input buffer is full is ignored: `in_byte` and bit 3 keep their values.
- R6: Status bit 1 is also 1 whenever `tx_busy` is 1, and follows it back to 0 once the buffer is empty.
- R7: Status bit 5 is 1 when the held byte came from the auxiliary device (`rx_from_aux`=1) and 0 when it came from the keyboard. It reads 0 whenever the output buffer is empty.
- R8: A `rx_timeout` pulse loads 0xFF, sets bit 6 and clears bit 7.
- R9: A `dev_parity_err` pulse loads 0xFE and sets both bit 6 and bit 7. It wins over a `rx_timeout` pulse in the same cycle.
- R10: A received byte with `rx_parity_ok`=0 (even parity) loads 0xFF in its place, sets bit 7 and clears bit 6. A byte with `rx_parity_ok`=1 is loaded as is and clears bits 6 and 7.
- R11: An error event loads its code even when the output buffer is full, replacing the held byte. If it falls in the same cycle as a host data read, the read returns the old byte and bit 0 stays 1 with the new code held.
- R12: Status bit 2 is 0 after reset. A `selftest_pass` pulse sets it. A `cfg_sysflag_wr` pulse copies `cfg_sysflag_val` into it, and `selftest_pass` wins when both arrive together.
- R13: Status bit 4 is the inverse of `kbd_inhibit`.
- R14: After reset, both buffers are empty and every stored status bit is 0, so the status byte reads 0x10 when `kbd_inhibit`=0 and `tx_busy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Host chip select |
| addr | input | 1 | 0 = data port, 1 = command/status port |
| rd | input | 1 | Host read strobe |
| wr | input | 1 | Host write strobe |
| wdata | input | DW | Host write data |
| rdata | output | DW | Host read data |
| rx_valid | input | 1 | Received byte offered |
| rx_byte | input | DW | Received byte |
| rx_from_aux | input | 1 | Byte came from the auxiliary device |
| rx_parity_ok | input | 1 | Byte had odd parity |
| rx_ready | output | 1 | Output buffer can accept a byte |
| rx_timeout | input | 1 | Receive timeout pulse |
| dev_parity_err | input | 1 | Device reported a bad-parity byte pulse |
| tx_busy | input | 1 | Transmit to a device in progress |
| selftest_pass | input | 1 | Self-test passed pulse |
| cfg_sysflag_wr | input | 1 | Configuration write pulse |
| cfg_sysflag_val | input | 1 | System flag value in that write |
| kbd_inhibit | input | 1 | Keyboard inhibited |
| in_valid | output | 1 | Host byte waiting for the internal side |
| in_byte | output | DW | Host byte |
| in_is_cmd | output | 1 | Host byte came through the command port |
| in_take | input | 1 | Internal side consumes the host byte |

## Verification
The coincidence that matters most is a host data read landing in the same cycle as an error event that loads a substitute code. The read would empty the output buffer while the load fills it again. The bench provokes this by raising `rx_timeout` in the very cycle it holds a data-port read on a full buffer. It then judges three things: the read returns the old byte, bit 0 is still set afterwards, and the next read returns 0xFF. A second coincidence, a device parity fault alongside a timeout, is also driven in one cycle, and the bench expects 0xFE with both error bits set.

// File: rtl/kbd_host_pkg.sv
package kbd_host_pkg;

    typedef enum logic {
        OB_EMPTY,
        OB_FULL
    } ob_state_e;

    typedef enum logic {
        IB_EMPTY,
        IB_FULL
    } ib_state_e;

    typedef enum logic [1:0] {
        LD_NONE,
        LD_RXBYTE,
        LD_TIMEOUT,
        LD_DEVPAR
    } load_kind_e;

    localparam int ST_OBF  = 0;
    localparam int ST_IBF  = 1;
    localparam int ST_SYS  = 2;
    localparam int ST_CMD  = 3;
    localparam int ST_NINH = 4;
    localparam int ST_AUX  = 5;
    localparam int ST_TMO  = 6;
    localparam int ST_PAR  = 7;
    localparam int ST_W    = 8;

endpackage

// File: rtl/kbd_obuf.sv
module kbd_obuf
    import kbd_host_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    input  logic          rx_from_aux,
    input  logic          rx_parity_ok,
    input  logic          rx_timeout,
    input  logic          dev_parity_err,
    input  logic          host_rd_data,
    output logic          rx_ready,
    output logic          ob_full,
    output logic [DW-1:0] ob_data,
    output logic          ob_aux,
    output logic          err_tmo,
    output logic          err_par
);

    localparam logic [DW-1:0] TMO_CODE = '1;
    localparam logic [DW-1:0] DPE_CODE = {{(DW-1){1'b1}}, 1'b0};

    ob_state_e  state_q, state_d;
    load_kind_e kind;

    // Error events outrank a received byte; a byte needs an empty buffer.
    always_comb begin
        if (dev_parity_err)
            kind = LD_DEVPAR;
        else if (rx_timeout)
            kind = LD_TIMEOUT;
        else if (rx_valid && state_q == OB_EMPTY)
            kind = LD_RXBYTE;
        else
            kind = LD_NONE;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OB_EMPTY: if (kind != LD_NONE) state_d = OB_FULL;
            OB_FULL: begin
                if (kind != LD_NONE)
                    state_d = OB_FULL;      // replace
                else if (host_rd_data)
                    state_d = OB_EMPTY;     // host data read
            end
            default: state_d = OB_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OB_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ob_data <= '0;
            ob_aux  <= 1'b0;
            err_tmo <= 1'b0;
            err_par <= 1'b0;
        end else begin
            unique case (kind)
                LD_DEVPAR: begin
                    ob_data <= DPE_CODE;
                    ob_aux  <= 1'b0;
                    err_tmo <= 1'b1;
                    err_par <= 1'b1;
                end
                LD_TIMEOUT: begin
                    ob_data <= TMO_CODE;
                    ob_aux  <= 1'b0;
                    err_tmo <= 1'b1;
                    err_par <= 1'b0;
                end
                LD_RXBYTE: begin
                    ob_data <= rx_parity_ok ? rx_byte : TMO_CODE;
                    ob_aux  <= rx_from_aux;
                    err_tmo <= 1'b0;
                    err_par <= !rx_parity_ok;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rx_ready = (state_q == OB_EMPTY);
        ob_full  = (state_q == OB_FULL);
    end

endmodule

// File: rtl/kbd_ibuf.sv
module kbd_ibuf
    import kbd_host_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic          host_is_cmd,
    input  logic [DW-1:0] wdata,
    input  logic          in_take,
    output logic          in_valid,
    output logic [DW-1:0] in_byte,
    output logic          in_is_cmd
);

    ib_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IB_EMPTY: if (host_wr) state_d = IB_FULL;   // host write
            IB_FULL:  if (in_take) state_d = IB_EMPTY;  // take
            default:  state_d = IB_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IB_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_byte   <= '0;
            in_is_cmd <= 1'b0;
        end else if (state_q == IB_EMPTY && host_wr) begin
            in_byte   <= wdata;
            in_is_cmd <= host_is_cmd;
        end
    end

    always_comb begin
        in_valid = (state_q == IB_FULL);
    end

endmodule

// File: rtl/kbd_sysflag.sv
module kbd_sysflag (
    input  logic clk,
    input  logic rst_n,
    input  logic selftest_pass,
    input  logic cfg_sysflag_wr,
    input  logic cfg_sysflag_val,
    output logic sys_flag
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sys_flag <= 1'b0;
        else if (selftest_pass)
            sys_flag <= 1'b1;
        else if (cfg_sysflag_wr)
            sys_flag <= cfg_sysflag_val;
    end

endmodule

// File: rtl/kbd_host_regs.sv
module kbd_host_regs
    import kbd_host_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          addr,
    input  logic          rd,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    input  logic          rx_from_aux,
    input  logic          rx_parity_ok,
    output logic          rx_ready,
    input  logic          rx_timeout,
    input  logic          dev_parity_err,
    input  logic          tx_busy,
    input  logic          selftest_pass,
    input  logic          cfg_sysflag_wr,
    input  logic          cfg_sysflag_val,
    input  logic          kbd_inhibit,
    output logic          in_valid,
    output logic [DW-1:0] in_byte,
    output logic          in_is_cmd,
    input  logic          in_take
);

    logic          host_rd_data, host_rd_stat, host_wr;
    logic          ob_full, ob_aux, err_tmo, err_par, sys_flag;
    logic [DW-1:0] ob_data;
    logic [ST_W-1:0] status;

    always_comb begin
        host_rd_data = cs && rd && !addr;
        host_rd_stat = cs && rd && addr;
        host_wr      = cs && wr;
    end

    kbd_obuf #(.DW(DW)) i_obuf (
        .clk            (clk),
        .rst_n          (rst_n),
        .rx_valid       (rx_valid),
        .rx_byte        (rx_byte),
        .rx_from_aux    (rx_from_aux),
        .rx_parity_ok   (rx_parity_ok),
        .rx_timeout     (rx_timeout),
        .dev_parity_err (dev_parity_err),
        .host_rd_data   (host_rd_data),
        .rx_ready       (rx_ready),
        .ob_full        (ob_full),
        .ob_data        (ob_data),
        .ob_aux         (ob_aux),
        .err_tmo        (err_tmo),
        .err_par        (err_par)
    );

    kbd_ibuf #(.DW(DW)) i_ibuf (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_wr     (host_wr),
        .host_is_cmd (addr),
        .wdata       (wdata),
        .in_take     (in_take),
        .in_valid    (in_valid),
        .in_byte     (in_byte),
        .in_is_cmd   (in_is_cmd)
    );

    kbd_sysflag i_sysflag (
        .clk             (clk),
        .rst_n           (rst_n),
        .selftest_pass   (selftest_pass),
        .cfg_sysflag_wr  (cfg_sysflag_wr),
        .cfg_sysflag_val (cfg_sysflag_val),
        .sys_flag        (sys_flag)
    );

    always_comb begin
        status          = '0;
        status[ST_OBF]  = ob_full;
        status[ST_IBF]  = in_valid || tx_busy;
        status[ST_SYS]  = sys_flag;
        status[ST_CMD]  = in_is_cmd;
        status[ST_NINH] = !kbd_inhibit;
        status[ST_AUX]  = ob_full && ob_aux;
        status[ST_TMO]  = err_tmo;
        status[ST_PAR]  = err_par;
    end

    always_comb begin
        rdata = '0;
        if (host_rd_stat)
            rdata[ST_W-1:0] = status;
        else if (host_rd_data)
            rdata = ob_data;
    end

endmodule

// File: rtl/kbd_host_regs_chk.sv
module kbd_host_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs,
    input logic       addr,
    input logic       rd,
    input logic       rx_timeout,
    input logic       dev_parity_err,
    input logic       in_take,
    input logic       in_valid,
    input logic [7:0] in_byte_lo,
    input logic       rx_ready,
    input logic [7:0] status
);

    p_status_read_keeps_obf_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && cs && rd && addr) |=> status[0]);

    p_data_read_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && cs && rd && !addr && !rx_timeout && !dev_parity_err) |=> !status[0]);

    p_full_refuses_rx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] |-> !rx_ready);

    p_ib_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_take) |=> status[1]);

    p_ib_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_take) |=> (in_valid && $stable(in_byte_lo)));

    p_aux_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !status[0] |-> !status[5]);

    p_timeout_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_timeout && !dev_parity_err) |=> (status[0] && status[6] && !status[7]));

    p_devpar_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dev_parity_err |=> (status[0] && status[6] && status[7]));

endmodule

bind kbd_host_regs kbd_host_regs_chk i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cs             (cs),
    .addr           (addr),
    .rd             (rd),
    .rx_timeout     (rx_timeout),
    .dev_parity_err (dev_parity_err),
    .in_take        (in_take),
    .in_valid       (in_valid),
    .in_byte_lo     (in_byte[7:0]),
    .rx_ready       (rx_ready),
    .status         (status)
);

// File: tb/test_kbd_host_regs.sv
module test_kbd_host_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 0, addr = 0, rd = 0, wr = 0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rx_valid = 0, rx_from_aux = 0, rx_parity_ok = 1;
    logic [7:0] rx_byte = '0;
    logic       rx_ready;
    logic       rx_timeout = 0, dev_parity_err = 0, tx_busy = 0;
    logic       selftest_pass = 0, cfg_sysflag_wr = 0, cfg_sysflag_val = 0;
    logic       kbd_inhibit = 0;
    logic       in_valid, in_is_cmd, in_take = 0;
    logic [7:0] in_byte;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    kbd_host_regs #(.DW(8)) i_kbd_host_regs (
        .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .rd(rd), .wr(wr),
        .wdata(wdata), .rdata(rdata), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_from_aux(rx_from_aux), .rx_parity_ok(rx_parity_ok), .rx_ready(rx_ready),
        .rx_timeout(rx_timeout), .dev_parity_err(dev_parity_err), .tx_busy(tx_busy),
        .selftest_pass(selftest_pass), .cfg_sysflag_wr(cfg_sysflag_wr),
        .cfg_sysflag_val(cfg_sysflag_val), .kbd_inhibit(kbd_inhibit),
        .in_valid(in_valid), .in_byte(in_byte), .in_is_cmd(in_is_cmd), .in_take(in_take)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic host_read(input logic a, output logic [7:0] v);
        @(negedge clk);
        cs = 1; rd = 1; addr = a;
        #1 v = rdata;
        @(negedge clk);
        cs = 0; rd = 0; addr = 0;
    endtask

    task automatic host_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        cs = 1; wr = 1; addr = a; wdata = d;
        @(negedge clk);
        cs = 0; wr = 0; addr = 0;
    endtask

    task automatic rx_send(input logic [7:0] b, input logic aux, input logic ok);
        @(negedge clk);
        rx_valid = 1; rx_byte = b; rx_from_aux = aux; rx_parity_ok = ok;
        @(negedge clk);
        rx_valid = 0; rx_from_aux = 0; rx_parity_ok = 1;
    endtask

    task automatic pulse_err(input logic tmo, input logic dpe);
        @(negedge clk);
        rx_timeout = tmo; dev_parity_err = dpe;
        @(negedge clk);
        rx_timeout = 0; dev_parity_err = 0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk("R14 rx_ready after reset", {7'd0, rx_ready}, 8'h01);
        chk("R1 idle rdata zero", rdata, 8'h00);
        host_read(1, v);
        chk("R14 reset status", v, 8'h10);
    endtask

    task automatic t_basic_rx;
        logic [7:0] v;
        rx_send(8'h5A, 0, 1);
        host_read(1, v); chk("R2 status after load", v, 8'h11);
        host_read(1, v); chk("R1 status reread unchanged", v, 8'h11);
        host_read(0, v); chk("R2 data byte", v, 8'h5A);
        host_read(1, v); chk("R2 bit0 cleared after read", v, 8'h10);
    endtask

    task automatic t_aux_rx;
        logic [7:0] v;
        rx_send(8'h33, 1, 1);
        host_read(1, v); chk("R7 aux source bit", v, 8'h31);
        host_read(0, v); chk("R7 aux data", v, 8'h33);
        host_read(1, v); chk("R7 bit5 zero when empty", v, 8'h10);
    endtask

    task automatic t_full_refuse;
        logic [7:0] v;
        rx_send(8'h11, 0, 1);
        chk("R3 rx_ready low when full", {7'd0, rx_ready}, 8'h00);
        rx_send(8'h22, 1, 1);
        host_read(1, v); chk("R3 status unchanged by refused byte", v, 8'h11);
        host_read(0, v); chk("R3 held byte kept", v, 8'h11);
        chk("R3 rx_ready high when empty", {7'd0, rx_ready}, 8'h01);
    endtask

    task automatic t_parity;
        logic [7:0] v;
        rx_send(8'h44, 0, 0);
        host_read(1, v); chk("R10 even parity status", v, 8'h91);
        host_read(0, v); chk("R10 even parity substitute", v, 8'hFF);
        rx_send(8'h45, 0, 1);
        host_read(1, v); chk("R10 good byte clears errors", v, 8'h11);
        host_read(0, v); chk("R10 good byte data", v, 8'h45);
    endtask

    task automatic t_errors;
        logic [7:0] v;
        pulse_err(1, 0);
        host_read(1, v); chk("R8 timeout status", v, 8'h51);
        host_read(0, v); chk("R8 timeout code", v, 8'hFF);
        pulse_err(0, 1);
        host_read(1, v); chk("R9 device parity status", v, 8'hD1);
        host_read(0, v); chk("R9 device parity code", v, 8'hFE);
        pulse_err(1, 1);
        host_read(1, v); chk("R9 both events status", v, 8'hD1);
        host_read(0, v); chk("R9 device parity wins", v, 8'hFE);
    endtask

    task automatic t_replace;
        logic [7:0] v;
        rx_send(8'h12, 0, 1);
        pulse_err(1, 0);
        host_read(0, v); chk("R11 error replaces full buffer", v, 8'hFF);
        rx_send(8'h12, 0, 1);
        @(negedge clk);
        cs = 1; rd = 1; addr = 0; rx_timeout = 1;
        #1 v = rdata;
        @(negedge clk);
        cs = 0; rd = 0; rx_timeout = 0;
        chk("R11 coincident read returns old byte", v, 8'h12);
        host_read(1, v); chk("R11 bit0 stays after coincident load", v & 8'h41, 8'h41);
        host_read(0, v); chk("R11 new code held", v, 8'hFF);
    endtask

    task automatic t_host_write;
        logic [7:0] v;
        host_write(0, 8'hA5);
        host_read(1, v); chk("R4 data write status bits", v & 8'h0A, 8'h02);
        chk("R4 in_byte data", in_byte, 8'hA5);
        chk("R4 in_valid/in_is_cmd", {6'd0, in_valid, in_is_cmd}, 8'h02);
        host_write(1, 8'h60);
        chk("R5 write while full ignored", in_byte, 8'hA5);
        host_read(1, v); chk("R5 bit3 unchanged", v & 8'h0A, 8'h02);
        @(negedge clk); in_take = 1; @(negedge clk); in_take = 0;
        host_read(1, v); chk("R4 take clears bit1", v & 8'h0A, 8'h00);
        host_write(1, 8'hAA);
        host_read(1, v); chk("R4 command write bits", v & 8'h0A, 8'h0A);
        chk("R4 in_is_cmd command", {7'd0, in_is_cmd}, 8'h01);
        @(negedge clk); in_take = 1; @(negedge clk); in_take = 0;
        host_read(1, v); chk("R4 bit3 kept after take", v & 8'h0A, 8'h08);
    endtask

    task automatic t_tx_busy;
        logic [7:0] v;
        @(negedge clk); tx_busy = 1;
        host_read(1, v); chk("R6 tx busy sets bit1", v & 8'h02, 8'h02);
        tx_busy = 0;
        host_read(1, v); chk("R6 bit1 drops after tx", v & 8'h02, 8'h00);
    endtask

    task automatic t_sysflag;
        logic [7:0] v;
        @(negedge clk); selftest_pass = 1; @(negedge clk); selftest_pass = 0;
        host_read(1, v); chk("R12 self test sets flag", v & 8'h04, 8'h04);
        @(negedge clk); cfg_sysflag_wr = 1; cfg_sysflag_val = 0;
        @(negedge clk); cfg_sysflag_wr = 0;
        host_read(1, v); chk("R12 config clears flag", v & 8'h04, 8'h00);
        @(negedge clk); cfg_sysflag_wr = 1; selftest_pass = 1;
        @(negedge clk); cfg_sysflag_wr = 0; selftest_pass = 0;
        host_read(1, v); chk("R12 self test wins", v & 8'h04, 8'h04);
        @(negedge clk); cfg_sysflag_wr = 1; cfg_sysflag_val = 1;
        @(negedge clk); cfg_sysflag_wr = 0; cfg_sysflag_val = 0;
        host_read(1, v); chk("R12 config sets flag", v & 8'h04, 8'h04);
    endtask

    task automatic t_inhibit;
        logic [7:0] v;
        @(negedge clk); kbd_inhibit = 1;
        host_read(1, v); chk("R13 inhibited bit4", v & 8'h10, 8'h00);
        kbd_inhibit = 0;
        host_read(1, v); chk("R13 released bit4", v & 8'h10, 8'h10);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        @(negedge clk);
        t_reset;
        t_basic_rx;
        t_aux_rx;
        t_full_refuse;
        t_parity;
        t_errors;
        t_replace;
        t_host_write;
        t_tx_busy;
        t_sysflag;
        t_inhibit;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule